// File: doc/BRIEF.md
# Write-Protection Key Sequencer

This block sits beside the page-load controller of a byte-alterable nonvolatile array. It sees every captured write cycle as one beat: a strobe, an address and a data byte. For each beat it decides, in the same cycle, whether the page controller may program the byte (`wr_permit`) or must drop it as a key byte (`wr_is_cmd`). It keeps a protection flag that stands for the nonvolatile lock bit. The flag is clear after reset. The block modifies the flag only in response to fixed address/data key sequences.

Two key sequences are recognised.

- The three-beat unlock sequence sets the flag and opens a single page-load window. The window accepts up to `PAGE_BYTES` data bytes. It stays open until the page controller reports that the load has finished.
- The six-beat clear sequence returns the block to open operation, after a programmed settle delay.

A key sequence must arrive without other writes in between. Any write that breaks a sequence sends the matcher back to idle, except that a lead byte restarts it at the first step. While the flag is clear, the non-final key beats are ordinary data writes. Only the terminating bytes of a sequence are withheld from the array.

Top module: `wp_cmd_seq`

## Requirements
- R1: After reset, `protected_o` and `window_o` are 0, and any write is permitted (`wr_permit`=1, `wr_is_cmd`=0).
- R2: The beats AAh@1555h, 55h@0AAAh, A0h@1555h in that order set `protected_o` and `window_o` from the cycle after the A0h beat. While protected, each of these beats gives `wr_is_cmd`=1 and `wr_permit`=0.
- R3: Inside an open window, the first `PAGE_BYTES` (default 64) writes are permitted and any further writes are blocked. Neither kind is a key byte. A `load_done` pulse closes the window from the next cycle, and protection stays set.
- R4: While protected with no window, a write that is not a key step is blocked (`wr_permit`=0, `wr_is_cmd`=0).
- R5: The beats AAh@1555h, 55h@0AAAh, 80h@1555h, AAh@1555h, 55h@0AAAh, 20h@1555h complete the clear sequence. `protected_o` stays 1 for `CLEAR_DELAY`−1 (default 15) further clock edges after the edge that takes the 20h beat. It drops to 0 on the edge after that. Afterwards plain writes are permitted.
- R6: While unprotected, a key beat that does not end a sequence is permitted as data (`wr_permit`=1, `wr_is_cmd`=0). The terminating A0h, 80h and 20h beats give `wr_is_cmd`=1 and `wr_permit`=0.
- R7: A write that does not match the next expected key step returns the matcher to idle. A later continuation of the broken sequence therefore completes nothing.
- R8: A breaking write that is itself AAh@1555h counts as step one of a fresh sequence.
- R9: An unlock sequence completed while a clear is pending cancels the clear, and protection stays set.
- R10: `wr_permit` and `wr_is_cmd` are never both 1, and both are 0 whenever `wr_valid` is 0.
- R11: Writes inside an open window are never decoded as key beats, even when they carry key addresses and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One captured write beat this cycle |
| wr_addr | input | ADDR_W | Address of the beat |
| wr_data | input | 8 | Data byte of the beat |
| load_done | input | 1 | Page controller reports the load cycle finished |
| wr_permit | output | 1 | Beat may be programmed into the array |
| wr_is_cmd | output | 1 | Beat is a key byte and must be dropped |
| protected_o | output | 1 | Protection flag |
| window_o | output | 1 | A page-load window is open |

## Verification
The assertions assume the following about the inputs:

- `load_done` is a single-cycle pulse from the page controller.
- Write beats last exactly one cycle.
- Address bits above bit 12 are zero whenever a key address is intended.

The stimulus keeps to these assumptions. Every write is a one-cycle strobe followed by an idle cycle. `load_done` is raised only as an isolated one-cycle pulse. Only 13-bit addresses are driven. Clear-delay timing is measured with no intervening writes, so the count of clock edges since the 20h beat is exact.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int KEY_AW = 13;
    localparam int DATA_W = 8;

    localparam logic [KEY_AW-1:0] KA_HI = 13'h1555;
    localparam logic [KEY_AW-1:0] KA_LO = 13'h0AAA;

    localparam logic [DATA_W-1:0] KD_LEAD   = 8'hAA;
    localparam logic [DATA_W-1:0] KD_SECOND = 8'h55;
    localparam logic [DATA_W-1:0] KD_OPEN   = 8'hA0;
    localparam logic [DATA_W-1:0] KD_PRECLR = 8'h80;
    localparam logic [DATA_W-1:0] KD_CLEAR  = 8'h20;

    typedef enum logic [2:0] {
        M_IDLE,
        M_K1,
        M_K2,
        M_D3,
        M_D4,
        M_D5
    } match_st_e;

    typedef struct packed {
        logic hit;
        logic final_step;
        logic unlock;
        logic clear_req;
    } key_evt_t;

    typedef struct packed {
        match_st_e nxt;
        key_evt_t  evt;
    } step_res_t;

    function automatic step_res_t key_step(
        input match_st_e         st,
        input logic              at_hi,
        input logic              at_lo,
        input logic [DATA_W-1:0] d
    );
        step_res_t r;
        logic lead;
        logic second;
        lead   = at_hi && (d == KD_LEAD);
        second = at_lo && (d == KD_SECOND);
        r.nxt  = M_IDLE;
        r.evt  = '0;
        case (st)
            M_IDLE: if (lead) begin
                r.nxt = M_K1;
                r.evt.hit = 1'b1;
            end
            M_K1: if (second) begin
                r.nxt = M_K2;
                r.evt.hit = 1'b1;
            end
            M_K2: begin
                if (at_hi && d == KD_OPEN) begin
                    r.nxt = M_IDLE;
                    r.evt.hit = 1'b1;
                    r.evt.final_step = 1'b1;
                    r.evt.unlock = 1'b1;
                end else if (at_hi && d == KD_PRECLR) begin
                    r.nxt = M_D3;
                    r.evt.hit = 1'b1;
                    r.evt.final_step = 1'b1;
                end
            end
            M_D3: if (lead) begin
                r.nxt = M_D4;
                r.evt.hit = 1'b1;
            end
            M_D4: if (second) begin
                r.nxt = M_D5;
                r.evt.hit = 1'b1;
            end
            M_D5: if (at_hi && d == KD_CLEAR) begin
                r.nxt = M_IDLE;
                r.evt.hit = 1'b1;
                r.evt.final_step = 1'b1;
                r.evt.clear_req = 1'b1;
            end
            default: r.nxt = M_IDLE;
        endcase
        if (!r.evt.hit && lead) begin
            r.nxt = M_K1;
            r.evt.hit = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/wp_key_matcher.sv
module wp_key_matcher
    import wp_pkg::*;
#(
    parameter int ADDR_W = KEY_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hold,
    output key_evt_t          evt
);

    match_st_e st;
    step_res_t res;
    logic      at_hi;
    logic      at_lo;

    assign at_hi = (wr_addr == ADDR_W'(KA_HI));
    assign at_lo = (wr_addr == ADDR_W'(KA_LO));

    always_comb begin
        res = key_step(st, at_hi, at_lo, wr_data);
        evt = (wr_valid && !hold) ? res.evt : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= M_IDLE;
        end else if (hold) begin
            st <= M_IDLE;
        end else if (wr_valid) begin
            st <= res.nxt;
        end
    end

    // R11
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> (st == M_IDLE));

    // R7
    miss_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !hold && !evt.hit) |=> (st == M_IDLE));

endmodule

// File: rtl/wp_window.sv
module wp_window #(
    parameter int PAGE_BYTES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic open_req,
    input  logic close_req,
    input  logic wr_valid,
    output logic win_open,
    output logic win_room
);

    localparam int CW = $clog2(PAGE_BYTES + 1);

    logic [CW-1:0] cnt;

    assign win_room = (cnt < CW'(PAGE_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            win_open <= 1'b0;
            cnt      <= '0;
        end else if (open_req) begin
            win_open <= 1'b1;
            cnt      <= '0;
        end else if (close_req) begin
            win_open <= 1'b0;
            cnt      <= '0;
        end else if (win_open && wr_valid && win_room) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(PAGE_BYTES));

    // R3
    close_chk: assert property (@(posedge clk) disable iff (rst)
        (close_req && !open_req) |=> !win_open);

endmodule

// File: rtl/wp_flag.sv
module wp_flag #(
    parameter int CLEAR_DELAY = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic prot
);

    localparam int TW = (CLEAR_DELAY > 1) ? $clog2(CLEAR_DELAY) : 1;

    logic          pend;
    logic [TW-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot <= 1'b0;
            pend <= 1'b0;
            tmr  <= '0;
        end else if (set_req) begin
            prot <= 1'b1;
            pend <= 1'b0;
            tmr  <= '0;
        end else if (clr_req) begin
            pend <= 1'b1;
            tmr  <= TW'(CLEAR_DELAY - 1);
        end else if (pend) begin
            if (tmr == '0) begin
                prot <= 1'b0;
                pend <= 1'b0;
            end else begin
                tmr <= tmr - 1'b1;
            end
        end
    end

    // R2
    rise_on_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(prot) |-> $past(set_req));

    // R5
    fall_after_timer_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(prot) |-> $past(pend));

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> prot);

endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
    import wp_pkg::*;
#(
    parameter int ADDR_W      = KEY_AW,
    parameter int PAGE_BYTES  = 64,
    parameter int CLEAR_DELAY = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              load_done,
    output logic              wr_permit,
    output logic              wr_is_cmd,
    output logic              protected_o,
    output logic              window_o
);

    key_evt_t evt;
    logic     win_open;
    logic     win_room;
    logic     prot;

    wp_key_matcher #(.ADDR_W(ADDR_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .hold     (win_open),
        .evt      (evt)
    );

    wp_window #(.PAGE_BYTES(PAGE_BYTES)) u_win (
        .clk       (clk),
        .rst       (rst),
        .open_req  (evt.unlock),
        .close_req (load_done),
        .wr_valid  (wr_valid),
        .win_open  (win_open),
        .win_room  (win_room)
    );

    wp_flag #(.CLEAR_DELAY(CLEAR_DELAY)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .set_req (evt.unlock),
        .clr_req (evt.clear_req),
        .prot    (prot)
    );

    always_comb begin
        wr_permit = 1'b0;
        wr_is_cmd = 1'b0;
        if (wr_valid) begin
            if (win_open) begin
                wr_permit = win_room;
            end else if (evt.hit && (prot || evt.final_step)) begin
                wr_is_cmd = 1'b1;
            end else begin
                wr_permit = !prot;
            end
        end
    end

    assign protected_o = prot;
    assign window_o    = win_open;

    // R10
    permit_cmd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_permit && wr_is_cmd));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |-> (!wr_permit && !wr_is_cmd));

    // R3
    window_needs_prot_chk: assert property (@(posedge clk) disable iff (rst)
        window_o |-> protected_o);

    // R4
    locked_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && protected_o && !window_o) |-> !wr_permit);

    // R2
    unlock_opens_chk: assert property (@(posedge clk) disable iff (rst)
        evt.unlock |=> (window_o && protected_o));

endmodule

// File: tb/tb_wp_cmd_seq.sv
module tb_wp_cmd_seq;

    localparam int AW   = 13;
    localparam int PG   = 64;
    localparam int CDLY = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          load_done;
    logic          wr_permit;
    logic          wr_is_cmd;
    logic          protected_o;
    logic          window_o;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    wp_cmd_seq #(.ADDR_W(AW), .PAGE_BYTES(PG), .CLEAR_DELAY(CDLY)) dut (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .load_done   (load_done),
        .wr_permit   (wr_permit),
        .wr_is_cmd   (wr_is_cmd),
        .protected_o (protected_o),
        .window_o    (window_o)
    );

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                      input logic ep, input logic ec, input string rq);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        #1;
        checks++;
        if (wr_permit !== ep || wr_is_cmd !== ec) begin
            failures++;
            $display("FAIL %s wr %h@%h permit/cmd got %b%b exp %b%b",
                     rq, d, a, wr_permit, wr_is_cmd, ep, ec);
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic chk_state(input logic ep, input logic ew, input string rq);
        #1;
        checks++;
        if (protected_o !== ep || window_o !== ew) begin
            failures++;
            $display("FAIL %s prot/win got %b%b exp %b%b",
                     rq, protected_o, window_o, ep, ew);
        end
    endtask

    task automatic pulse_done();
        @(negedge clk);
        load_done = 1'b1;
        @(negedge clk);
        load_done = 1'b0;
    endtask

    task automatic unlock(input logic prot_now, input string rq);
        wr(13'h1555, 8'hAA, !prot_now, prot_now, rq);
        wr(13'h0AAA, 8'h55, !prot_now, prot_now, rq);
        wr(13'h1555, 8'hA0, 1'b0, 1'b1, rq);
    endtask

    task automatic clear_seq(input string rq);
        wr(13'h1555, 8'hAA, 1'b0, 1'b1, rq);
        wr(13'h0AAA, 8'h55, 1'b0, 1'b1, rq);
        wr(13'h1555, 8'h80, 1'b0, 1'b1, rq);
        wr(13'h1555, 8'hAA, 1'b0, 1'b1, rq);
        wr(13'h0AAA, 8'h55, 1'b0, 1'b1, rq);
        wr(13'h1555, 8'h20, 1'b0, 1'b1, rq);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1;
        wr_valid = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        load_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state and open writes
        chk_state(1'b0, 1'b0, "R1");
        wr(13'h0123, 8'h5A, 1'b1, 1'b0, "R1");

        // R10 quiet when no strobe
        @(negedge clk);
        #1;
        checks++;
        if (wr_permit !== 1'b0 || wr_is_cmd !== 1'b0) begin
            failures++;
            $display("FAIL R10 idle got %b%b exp 00", wr_permit, wr_is_cmd);
        end

        // R6 unprotected sweep of every data byte at the lead address
        for (int d = 0; d < 256; d++) begin
            wr(13'h1555, 8'(d), 1'b1, 1'b0, "R6");
        end
        wr(13'h0777, 8'hFF, 1'b1, 1'b0, "R6");

        // R2 R6 unlock from unprotected state
        unlock(1'b0, "R2");
        chk_state(1'b1, 1'b1, "R2");

        // R3 R11 window fill, key-looking writes first
        wr(13'h1555, 8'hAA, 1'b1, 1'b0, "R11");
        wr(13'h0AAA, 8'h55, 1'b1, 1'b0, "R11");
        wr(13'h1555, 8'hA0, 1'b1, 1'b0, "R11");
        for (int i = 3; i < PG; i++) begin
            wr(13'h0040 + 13'(i), 8'(i), 1'b1, 1'b0, "R3");
        end
        wr(13'h0040, 8'h01, 1'b0, 1'b0, "R3");
        pulse_done();
        chk_state(1'b1, 1'b0, "R3");

        // R4 R8 protected sweep: only the lead byte is a key step
        for (int d = 0; d < 256; d++) begin
            wr(13'h1555, 8'(d), 1'b0, (d == 8'hAA), "R4");
        end
        wr(13'h0100, 8'h33, 1'b0, 1'b0, "R4");
        wr(13'h0AAA, 8'h55, 1'b0, 1'b0, "R4");

        // R7 interrupted sequence completes nothing
        wr(13'h1555, 8'hAA, 1'b0, 1'b1, "R7");
        wr(13'h0AAA, 8'h55, 1'b0, 1'b1, "R7");
        wr(13'h0100, 8'h12, 1'b0, 1'b0, "R7");
        wr(13'h1555, 8'hA0, 1'b0, 1'b0, "R7");
        chk_state(1'b1, 1'b0, "R7");

        // R8 lead byte restarts the sequence
        wr(13'h1555, 8'hAA, 1'b0, 1'b1, "R8");
        wr(13'h1555, 8'hAA, 1'b0, 1'b1, "R8");
        wr(13'h0AAA, 8'h55, 1'b0, 1'b1, "R8");
        wr(13'h1555, 8'hA0, 1'b0, 1'b1, "R8");
        chk_state(1'b1, 1'b1, "R8");
        pulse_done();

        // R5 clear sequence and settle delay
        clear_seq("R5");
        repeat (CDLY - 1) @(negedge clk);
        chk_state(1'b1, 1'b0, "R5");
        @(negedge clk);
        chk_state(1'b0, 1'b0, "R5");
        wr(13'h0200, 8'h44, 1'b1, 1'b0, "R5");

        // R9 unlock during pending clear keeps protection
        unlock(1'b0, "R9");
        pulse_done();
        clear_seq("R9");
        unlock(1'b1, "R9");
        repeat (CDLY + 4) @(negedge clk);
        chk_state(1'b1, 1'b1, "R9");
        pulse_done();
        wr(13'h0300, 8'h10, 1'b0, 1'b0, "R9");

        // R6 final clear steps withheld while unprotected
        clear_seq("R6");
        repeat (CDLY + 2) @(negedge clk);
        chk_state(1'b0, 1'b0, "R6");
        wr(13'h1555, 8'hAA, 1'b1, 1'b0, "R6");
        wr(13'h0AAA, 8'h55, 1'b1, 1'b0, "R6");
        wr(13'h1555, 8'h80, 1'b0, 1'b1, "R6");
        wr(13'h1555, 8'hAA, 1'b1, 1'b0, "R6");
        wr(13'h0AAA, 8'h55, 1'b1, 1'b0, "R6");
        wr(13'h1555, 8'h20, 1'b0, 1'b1, "R6");
        repeat (CDLY + 2) @(negedge clk);
        chk_state(1'b0, 1'b0, "R6");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule